// File: doc/BRIEF.md
# Eight-Stage Parallel-Load Serial Shift Register

This block holds an eight-bit word that can be captured in parallel and then moved out one bit at a time. A level-sensitive load control, active low, copies the eight parallel inputs into every stage for as long as it is held low. When the load control is high, shifting is allowed. Each shift moves the word one stage toward the serial output, and a serial data input fills the first stage.

Shifting follows a combined clock, which is the OR of two equivalent external clock pins. Either pin can act as the clock and the other as an inhibit: while one pin is high, the combined clock stays high and no edge can occur. The block runs on a free-running system clock. All external pins pass through a synchronizer two flops deep. A shift takes place on a rising edge of the combined clock, detected in the synchronized domain. A change on any input therefore shows at the serial output three system-clock cycles later.

Top module: `piso_shift8`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge of clk) clears all eight stages, so q_out is 0 and q_out_n is 1.
- R2: While ld_n is low, stage i takes par_in[i] for i = 0..7. Stage 7 drives q_out, so q_out equals par_in[7] three clk cycles after the inputs are applied.
- R3: While ld_n stays low, the stages follow every change on par_in. After ld_n rises, the stages keep the last value that par_in held.
- R4: While ld_n is low, edges on clk_a and clk_b have no effect on the stored word.
- R5: With ld_n high, each rising edge of the combined clock (clk_a OR clk_b) shifts the word once. Stage 0 takes ser_in, and stage k takes the old stage k-1.
- R6: q_out_n is always the complement of q_out.
- R7: While one clock pin is held high, any transition on the other pin causes no shift.
- R8: Raising one clock pin while the other is low is a rising edge of the combined clock and causes exactly one shift.
- R9: Holding the combined clock high causes no further shift, and a falling edge of the combined clock causes no shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Parallel load when low, shift enable when high |
| clk_a | input | 1 | External clock pin A |
| clk_b | input | 1 | External clock pin B, interchangeable with A |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel data, bit i to stage i |
| q_out | output | 1 | Serial output, stage 7 |
| q_out_n | output | 1 | Complement of q_out |

## Verification
A single wrong stage cannot be seen at once, because only stage 7 reaches the pins. It appears at q_out only after as many further shifts as it sits from the end. The bench therefore shifts every loaded or disturbed word all the way out and compares each bit. A spurious or missed shift is different: it changes q_out three cycles after the clock pin moves. The bench checks q_out right after each pin transition.

// File: rtl/piso_pkg.sv
package piso_pkg;
    typedef struct packed {
        logic ser;
        logic ck_b;
        logic ck_a;
        logic ld_n;
    } piso_ctrl_t;

    localparam int unsigned CTRL_W = $bits(piso_ctrl_t);
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int unsigned WIDTH = 12,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_in;
        for (int i = 1; i < int'(DEPTH); i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.pipe[DEPTH-1];
endmodule

// File: rtl/piso_clkgate.sv
module piso_clkgate (
    input  logic clk,
    input  logic rst_n,
    input  logic ck_a,
    input  logic ck_b,
    output logic rise
);
    typedef struct packed {
        logic eff;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        eff_now;

    always_comb begin
        eff_now  = ck_a | ck_b;
        st_d     = st_q;
        st_d.eff = eff_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = eff_now & ~st_q.eff;

    // R7
    inhibit_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_b && $past(ck_b)) |-> !rise);
    // R7
    inhibit_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_a && $past(ck_a)) |-> !rise);
    // R8
    hazard_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_b && !$past(ck_b) && !ck_a && !$past(ck_a)) |-> rise);
endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              shift_en,
    input  logic              ser,
    input  logic [STAGES-1:0] par,
    output logic [STAGES-1:0] stage_q
);
    typedef struct packed {
        logic [STAGES-1:0] stage;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!load_n) begin
            st_d.stage = par;
        end else if (shift_en) begin
            st_d.stage = {st_q.stage[STAGES-2:0], ser};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stage_q = st_q.stage;

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> stage_q == $past(par));
    // R5
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && shift_en) |=> stage_q == {$past(stage_q[STAGES-2:0]), $past(ser)});
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !shift_en) |=> $stable(stage_q));
endmodule

// File: rtl/piso_shift8.sv
module piso_shift8 #(
    parameter int unsigned STAGES     = 8,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              ser_in,
    input  logic [STAGES-1:0] par_in,
    output logic              q_out,
    output logic              q_out_n
);
    import piso_pkg::*;

    localparam int unsigned BUS_W = STAGES + CTRL_W;

    logic [BUS_W-1:0]  raw_bus;
    logic [BUS_W-1:0]  sync_bus;
    piso_ctrl_t        ctrl_s;
    logic [STAGES-1:0] par_s;
    logic              rise;
    logic [STAGES-1:0] stage_q;

    assign raw_bus = {par_in, ser_in, clk_b, clk_a, ld_n};

    piso_sync #(.WIDTH(BUS_W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_bus),
        .sync_out (sync_bus)
    );

    assign ctrl_s = piso_ctrl_t'(sync_bus[CTRL_W-1:0]);
    assign par_s  = sync_bus[BUS_W-1:CTRL_W];

    piso_clkgate u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .ck_a  (ctrl_s.ck_a),
        .ck_b  (ctrl_s.ck_b),
        .rise  (rise)
    );

    piso_stages #(.STAGES(STAGES)) u_stages (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (ctrl_s.ld_n),
        .shift_en (rise),
        .ser      (ctrl_s.ser),
        .par      (par_s),
        .stage_q  (stage_q)
    );

    assign q_out   = stage_q[STAGES-1];
    assign q_out_n = ~stage_q[STAGES-1];

    // R6
    compl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_out != q_out_n);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !q_out);
endmodule

// File: tb/tb_piso_shift8.sv
module tb_piso_shift8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_n = 1'b1;
    logic       clk_a = 1'b0;
    logic       clk_b = 1'b0;
    logic       ser_in = 1'b0;
    logic [7:0] par_in = '0;
    logic       q_out, q_out_n;

    typedef struct {
        logic  bitv;
        string req;
    } exp_t;

    exp_t       exp_q[$];
    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] model = '0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    piso_shift8 dut (
        .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .clk_a(clk_a), .clk_b(clk_b),
        .ser_in(ser_in), .par_in(par_in), .q_out(q_out), .q_out_n(q_out_n)
    );

    // monitor: pops one expectation per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (q_out !== e.bitv || q_out_n !== ~e.bitv) begin
                    n_bad++;
                    $display("FAIL %s: q_out=%b q_out_n=%b expected q_out=%b q_out_n=%b",
                             e.req, q_out, q_out_n, e.bitv, ~e.bitv);
                end
            end
        end
    end

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic expect_out(input string req);
        exp_t e;
        e.bitv = model[7];
        e.req  = req;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
    endtask

    task automatic shift_model(input logic s);
        if (ld_n) model = {model[6:0], s};
    endtask

    task automatic load_word(input logic [7:0] w);
        ld_n = 1'b0; par_in = w; settle();
        model = w;
        ld_n = 1'b1; settle();
    endtask

    task automatic pulse_a(input logic s);
        ser_in = s;
        clk_a = 1'b1; settle(); shift_model(s);
        clk_a = 1'b0; settle();
    endtask

    task automatic drain(input logic [7:0] pattern, input string req);
        for (int i = 7; i >= 0; i--) begin
            expect_out(req);
            pulse_a(pattern[i]);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        model = '0;
        // R1: cleared after reset
        expect_out("R1");

        // R2/R5/R6: random loads shifted out, serial pattern shifted in behind
        for (int k = 0; k < 4; k++) begin
            w = 8'($urandom);
            load_word(w);
            drain(8'b1100_1010, "R2");
            drain(8'h00, "R5");
        end

        // R3: follows par_in while ld_n low, last value kept
        ld_n = 1'b0; par_in = 8'h0F; settle();
        model = 8'h0F; expect_out("R3");
        par_in = 8'hF0; settle();
        model = 8'hF0; expect_out("R3");
        par_in = 8'h5C; settle();
        model = 8'h5C;
        ld_n = 1'b1; settle();
        par_in = 8'hFF; settle();
        drain(8'h00, "R3");

        // R4: clock edges ignored during load
        ld_n = 1'b0; par_in = 8'h96; settle();
        model = 8'h96;
        pulse_a(1'b1);
        ser_in = 1'b1; clk_b = 1'b1; settle(); clk_b = 1'b0; settle();
        expect_out("R4");
        ld_n = 1'b1; settle();
        drain(8'h00, "R4");

        // R7/R9: inhibit held high blocks other pin
        load_word(8'hAA);
        ser_in = 1'b1; clk_a = 1'b1; settle(); shift_model(1'b1);
        expect_out("R9");
        ser_in = 1'b0;
        clk_b = 1'b1; settle(); expect_out("R7");
        clk_a = 1'b0; settle(); expect_out("R7");
        clk_a = 1'b1; settle(); expect_out("R7");
        clk_a = 1'b0; settle(); expect_out("R7");
        clk_b = 1'b0; settle(); expect_out("R9");
        drain(8'h00, "R7");

        // R8: raising inhibit while clock low gives one shift
        load_word(8'hB4);
        ser_in = 1'b1; clk_b = 1'b1; settle(); shift_model(1'b1);
        expect_out("R8");
        clk_b = 1'b0; settle(); expect_out("R8");
        drain(8'h00, "R8");

        // R2: load in the middle of a shift sequence
        load_word(8'h3C);
        pulse_a(1'b1); pulse_a(1'b0); pulse_a(1'b1);
        expect_out("R5");
        load_word(8'hC3);
        drain(8'h81, "R2");
        drain(8'h00, "R5");

        // R1: reset in mid-word
        load_word(8'hFF);
        rst_n = 1'b0; settle(); rst_n = 1'b1; settle();
        model = '0;
        drain(8'h00, "R1");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule